// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a register-programmed general-purpose pin controller for up to 160 pins. Pins are handled in groups of 32. Each group holds six pieces of state: a direction word, an output word, a rising-edge enable word, a falling-edge enable word, a latched interrupt status word, and a synchronised view of its input pads. Software never writes the output word directly. It drives pins high or low by writing masks to separate set and clear words. The edge enables are changed the same way, through their own set and clear words. A captured edge is removed from status by writing a one to its bit.

Interrupts leave the block on bank lines of 16 pins each. Each bank line is gated by one bit of a bank-enable word. With the `DIRECT_CNT` parameter above zero, the lowest pins each get a dedicated interrupt line, and those pins no longer feed their bank line. Accesses come through a plain 32-bit read/write port with byte addresses. Read data is registered. An asynchronous active-low reset is released to the logic through a two-flop synchroniser.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every direction, output, edge-enable, status and bank-enable bit reads 0. All `pin_oe` bits are 1, and `pin_out`, `bank_irq` and `direct_irq` are 0.
- R2: A direction bit of 1 makes the pin an input (`pin_oe` low), and 0 makes it an output. The direction word is read and written at word 0 of a group.
- R3: Writing a mask to word 2 (set-data) drives the masked outputs high on the next cycle and leaves the other bits unchanged. Reads of words 1, 2 and 3 all return the current output word.
- R4: Writing a mask to word 3 (clear-data) drives the masked outputs low and leaves the other bits unchanged.
- R5: Writes to word 1 (output data) and word 4 (input data) have no effect, so outputs change only through words 2 and 3.
- R6: Word 4 returns pad levels through a two-flop synchroniser, whatever the pin direction. For a pad change just before clock edge N, a read strobed at edges N and N+1 returns the old level, and a read strobed at edge N+2 returns the new level.
- R7: Rising enables are set through word 5 and cleared through word 6. Falling enables are set through word 7 and cleared through word 8. Each pair returns the same enable word on read.
- R8: A rising edge latches the pin's status bit (word 9) when its rising enable is set, and a falling edge does the same when its falling enable is set. An edge whose enable is clear is ignored. For a pad change just before edge N, the bit is set at edge N+2.
- R9: Writing ones to word 9 clears those status bits and leaves the bits written as zero. If an edge and a clear hit the same bit in the same cycle, the bit stays set.
- R10: Bank line 2k is high when any of bits 15:0 of group k's status is set, and bank line 2k+1 when any of bits 31:16 is set. Bank line b is gated by bit b of the bank-enable word at byte address 0x08.
- R11: With `DIRECT_CNT`=D>0, `direct_irq[i]` follows status bit i of group 0 for i<D, and those bits are excluded from bank line 0. The remaining `direct_irq` bits are 0.
- R12: Group k starts at byte address 0x10+0x28·k with ten consecutive words (0..9). Unaligned, unmapped or absent addresses read 0 and write nothing. Bits above the last pin read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on `reg_rdata` after the edge |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Pad input levels |
| pin_out | output | NUM_PINS | Output data to pads |
| pin_oe | output | NUM_PINS | Output enable, high when the direction bit is 0 |
| bank_irq | output | ceil(NUM_PINS/16) | Per-bank interrupt lines |
| direct_irq | output | 32 | Dedicated per-pin interrupt lines in direct mode |

## Verification
The hardest case to reach from the ports is a status clear landing in the same cycle as a fresh edge on that bit. The edge only reaches status two edges after the pad moves. The bench therefore changes the pad on a falling clock edge and issues the clear write exactly two cycles later. It then repeats the sequence with the clear one cycle later, where the bit must end up cleared. Bank gating, the direct-mode exclusion and both edge polarities are swept over every pin of a 48-pin configuration. Two instances with and without dedicated lines share one stimulus.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 8;
  localparam int SET_PINS   = 32;
  localparam int BANK_PINS  = 16;
  localparam int SET_WORDS  = 10;
  localparam int SET_BASE0  = 'h10;
  localparam int SET_STRIDE = 'h28;
  localparam logic [ADDR_W-1:0] BANK_EN_OFS = 8'h08;

  // word index within a register group; the order is the address layout
  typedef enum logic [3:0] {
    REG_DIR      = 4'd0,
    REG_OUT      = 4'd1,
    REG_OUT_SET  = 4'd2,
    REG_OUT_CLR  = 4'd3,
    REG_IN       = 4'd4,
    REG_RISE_SET = 4'd5,
    REG_RISE_CLR = 4'd6,
    REG_FALL_SET = 4'd7,
    REG_FALL_CLR = 4'd8,
    REG_STAT     = 4'd9
  } set_reg_e;
endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] level,
  output logic [W-1:0] rose,
  output logic [W-1:0] fell
);
  logic [W-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_in;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign level = lvl_q;
  assign rose  = lvl_q & ~prev_q;
  assign fell  = ~lvl_q & prev_q;
endmodule

// File: rtl/gpio_reg_set.sv
module gpio_reg_set
  import gpio_bank_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [3:0]        idx,
  input  logic [LANES-1:0]  wdata,
  input  logic [LANES-1:0]  pad_in,
  output logic [LANES-1:0]  dir_pins,
  output logic [LANES-1:0]  out_pins,
  output logic [LANES-1:0]  stat_pins,
  output logic [WORD_W-1:0] rd_word
);
  logic [LANES-1:0] level, rose, fell;
  logic [LANES-1:0] dir_q, out_q, rise_q, fall_q, stat_q;
  logic [LANES-1:0] dir_d, out_d, rise_d, fall_d, stat_d, stat_clr;
  logic             cfg_en;

  gpio_edge_sync #(.W(LANES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pad_in (pad_in),
    .level  (level),
    .rose   (rose),
    .fell   (fell)
  );

  assign cfg_en = wr_hit;

  always_comb begin
    dir_d    = dir_q;
    out_d    = out_q;
    rise_d   = rise_q;
    fall_d   = fall_q;
    stat_clr = '0;
    if (wr_hit) begin
      case (idx)
        REG_DIR:      dir_d    = wdata;
        REG_OUT_SET:  out_d    = out_q | wdata;
        REG_OUT_CLR:  out_d    = out_q & ~wdata;
        REG_RISE_SET: rise_d   = rise_q | wdata;
        REG_RISE_CLR: rise_d   = rise_q & ~wdata;
        REG_FALL_SET: fall_d   = fall_q | wdata;
        REG_FALL_CLR: fall_d   = fall_q & ~wdata;
        REG_STAT:     stat_clr = wdata;
        default:      ;
      endcase
    end
    // a new edge is ORed in after the clear so it survives a same-cycle clear
    stat_d = (stat_q & ~stat_clr) | (rose & rise_q) | (fell & fall_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
    end else begin
      if (cfg_en) begin
        dir_q  <= dir_d;
        out_q  <= out_d;
        rise_q <= rise_d;
        fall_q <= fall_d;
      end
      stat_q <= stat_d;
    end
  end

  always_comb begin
    case (idx)
      REG_DIR:                           rd_word = WORD_W'(dir_q);
      REG_OUT, REG_OUT_SET, REG_OUT_CLR: rd_word = WORD_W'(out_q);
      REG_IN:                            rd_word = WORD_W'(level);
      REG_RISE_SET, REG_RISE_CLR:        rd_word = WORD_W'(rise_q);
      REG_FALL_SET, REG_FALL_CLR:        rd_word = WORD_W'(fall_q);
      REG_STAT:                          rd_word = WORD_W'(stat_q);
      default:                           rd_word = '0;
    endcase
  end

  assign dir_pins  = dir_q;
  assign out_pins  = out_q;
  assign stat_pins = stat_q;
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS   = 144,
  parameter int DIRECT_CNT = 0,
  parameter int NUM_BANKS  = 9
) (
  input  logic [NUM_PINS-1:0]  stat_pins,
  input  logic [NUM_BANKS-1:0] bank_en,
  output logic [NUM_BANKS-1:0] bank_irq,
  output logic [SET_PINS-1:0]  direct_irq
);
  localparam int PAD_W = NUM_BANKS * BANK_PINS;
  localparam logic [PAD_W-1:0] DIRECT_MASK = PAD_W'((64'd1 << DIRECT_CNT) - 64'd1);

  logic [PAD_W-1:0] stat_pad, bank_src;

  assign stat_pad = PAD_W'(stat_pins);
  assign bank_src = stat_pad & ~DIRECT_MASK;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_irq[b] = bank_en[b] & (|bank_src[b*BANK_PINS +: BANK_PINS]);
  end

  assign direct_irq = SET_PINS'(stat_pad & DIRECT_MASK);
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS   = 144,
  parameter int DIRECT_CNT = 0,
  localparam int NUM_BANKS = (NUM_PINS + BANK_PINS - 1) / BANK_PINS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  input  logic [NUM_PINS-1:0]  pin_in,
  output logic [NUM_PINS-1:0]  pin_out,
  output logic [NUM_PINS-1:0]  pin_oe,
  output logic [NUM_BANKS-1:0] bank_irq,
  output logic [SET_PINS-1:0]  direct_irq
);
  localparam int NUM_SETS = (NUM_PINS + SET_PINS - 1) / SET_PINS;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  logic                             aligned;
  logic [NUM_SETS-1:0]              set_hit;
  logic [NUM_SETS-1:0][3:0]         set_idx;
  logic [NUM_SETS-1:0][WORD_W-1:0]  set_rd;
  logic [NUM_PINS-1:0]              stat_pins;

  assign aligned = (reg_addr[1:0] == 2'b00);

  for (genvar k = 0; k < NUM_SETS; k++) begin : g_set
    localparam int BASE  = SET_BASE0 + k * SET_STRIDE;
    localparam int LANES = ((NUM_PINS - k * SET_PINS) > SET_PINS) ? SET_PINS
                                                                  : (NUM_PINS - k * SET_PINS);
    logic [ADDR_W-1:0] rel;
    logic [LANES-1:0]  dir_l, out_l, stat_l;

    assign rel        = reg_addr - ADDR_W'(BASE);
    assign set_hit[k] = aligned && (reg_addr >= ADDR_W'(BASE)) && (rel < ADDR_W'(SET_WORDS * 4));
    assign set_idx[k] = rel[5:2];

    gpio_reg_set #(.LANES(LANES)) i_set (
      .clk       (clk),
      .rst_n     (core_rst_n),
      .wr_hit    (reg_wr && set_hit[k]),
      .idx       (set_idx[k]),
      .wdata     (reg_wdata[LANES-1:0]),
      .pad_in    (pin_in[k*SET_PINS +: LANES]),
      .dir_pins  (dir_l),
      .out_pins  (out_l),
      .stat_pins (stat_l),
      .rd_word   (set_rd[k])
    );

    assign pin_out[k*SET_PINS +: LANES]   = out_l;
    assign pin_oe[k*SET_PINS +: LANES]    = ~dir_l;
    assign stat_pins[k*SET_PINS +: LANES] = stat_l;
  end

  // per-bank interrupt enable word
  logic                 bank_en_hit;
  logic [NUM_BANKS-1:0] bank_en_q, bank_en_d;
  logic                 bank_en_we;

  assign bank_en_hit = aligned && (reg_addr == BANK_EN_OFS);
  assign bank_en_we  = reg_wr && bank_en_hit;
  assign bank_en_d   = reg_wdata[NUM_BANKS-1:0];

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)     bank_en_q <= '0;
    else if (bank_en_we) bank_en_q <= bank_en_d;
  end

  // registered read path
  logic [WORD_W-1:0] rdata_d, rdata_q;

  always_comb begin
    rdata_d = '0;
    if (bank_en_hit) rdata_d = WORD_W'(bank_en_q);
    for (int k = 0; k < NUM_SETS; k++) begin
      if (set_hit[k]) rdata_d = rdata_d | set_rd[k];
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) rdata_q <= '0;
    else if (reg_rd) rdata_q <= rdata_d;
  end
  assign reg_rdata = rdata_q;

  gpio_irq_route #(
    .NUM_PINS   (NUM_PINS),
    .DIRECT_CNT (DIRECT_CNT),
    .NUM_BANKS  (NUM_BANKS)
  ) i_route (
    .stat_pins  (stat_pins),
    .bank_en    (bank_en_q),
    .bank_irq   (bank_irq),
    .direct_irq (direct_irq)
  );
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS   = 144,
  parameter int DIRECT_CNT = 0,
  parameter int NUM_BANKS  = 9
) (
  input logic                 clk,
  input logic                 core_rst_n,
  input logic                 reg_wr,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [WORD_W-1:0]    reg_wdata,
  input logic [NUM_PINS-1:0]  pin_out,
  input logic [NUM_BANKS-1:0] bank_irq,
  input logic [NUM_BANKS-1:0] bank_en_q,
  input logic [NUM_PINS-1:0]  stat_pins
);
  localparam int L0    = (NUM_PINS < SET_PINS) ? NUM_PINS : SET_PINS;
  localparam int PAD_W = NUM_BANKS * BANK_PINS;
  localparam logic [31:0] V0 = 32'((64'd1 << L0) - 64'd1);
  localparam logic [PAD_W-1:0] DMASK = PAD_W'((64'd1 << DIRECT_CNT) - 64'd1);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(SET_BASE0 + 4 * int'(REG_OUT_SET));
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(SET_BASE0 + 4 * int'(REG_OUT_CLR));
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(SET_BASE0 + 4 * int'(REG_STAT));

  logic [PAD_W-1:0] stat_pad;
  logic [31:0]      out0, stat0;

  assign stat_pad = PAD_W'(stat_pins);
  assign out0     = 32'(PAD_W'(pin_out)) & V0;
  assign stat0    = 32'(stat_pad) & V0;

  AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!core_rst_n)
    (reg_wr && reg_addr == A_SET) |=> ((out0 & $past(reg_wdata) & V0) == ($past(reg_wdata) & V0))); // R3

  AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!core_rst_n)
    (reg_wr && reg_addr == A_CLR) |=> ((out0 & $past(reg_wdata)) == 32'd0)); // R4

  AST_OUT_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!core_rst_n)
    !reg_wr |=> $stable(pin_out)); // R5

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(reg_wr && reg_addr == A_STAT) |=> ((stat0 & $past(stat0)) == $past(stat0))); // R9

  AST_BANK_GATED: assert property (@(posedge clk) disable iff (!core_rst_n)
    ((bank_irq & ~bank_en_q) == '0)); // R10

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    AST_BANK_SOURCE: assert property (@(posedge clk) disable iff (!core_rst_n)
      bank_irq[b] |-> (|(stat_pad[b*BANK_PINS +: BANK_PINS] & ~DMASK[b*BANK_PINS +: BANK_PINS]))); // R11
  end
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
  .NUM_PINS   (NUM_PINS),
  .DIRECT_CNT (DIRECT_CNT),
  .NUM_BANKS  (NUM_BANKS)
) i_chk (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .pin_out    (pin_out),
  .bank_irq   (bank_irq),
  .bank_en_q  (bank_en_q),
  .stat_pins  (stat_pins)
);

// File: tb/test_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module test_gpio_bank_ctrl;
  localparam int NP = 48;
  localparam int NB = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata_m, rdata_d;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] out_m, oe_m, out_d, oe_d;
  logic [NB-1:0] bank_m, bank_d;
  logic [31:0]   dirq_m, dirq_d;

  int n_chk = 0;
  int n_fail = 0;
  logic [NP-1:0] exp_out = '0;

  always #2.5 clk = ~clk;

  gpio_bank_ctrl #(.NUM_PINS(NP), .DIRECT_CNT(0)) i_gpio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_m), .pin_in(pin_in), .pin_out(out_m),
    .pin_oe(oe_m), .bank_irq(bank_m), .direct_irq(dirq_m));

  gpio_bank_ctrl #(.NUM_PINS(NP), .DIRECT_CNT(4)) i_gpio_bank_ctrl_direct (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_d), .pin_in(pin_in), .pin_out(out_d),
    .pin_oe(oe_d), .bank_irq(bank_d), .direct_irq(dirq_d));

  function automatic logic [7:0] ra(int s, int w);
    return 8'(16 + 40 * s + 4 * w);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // callers are aligned to a falling edge; the write is taken at the next rising edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = rdata_m;
  endtask

  task automatic summary_and_end();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary_and_end();
  end

  initial begin : main
    logic [31:0] v;
    tick(4);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < 10; w++) begin
        if (w != 4) begin rd(ra(s, w), v); chk("R1 reset word", 64'(v), 64'd0); end
      end
    end
    rd(8'h08, v); chk("R1 bank enable", 64'(v), 64'd0);
    chk("R1 pin_oe", 64'(oe_m), 64'hFFFF_FFFF_FFFF);
    chk("R1 pin_out", 64'(out_m), 64'd0);
    chk("R1 irq", 64'({bank_m, dirq_m, bank_d, dirq_d}), 64'd0);

    // R12 address map corners
    rd(8'h00, v); chk("R12 unmapped 0x00", 64'(v), 64'd0);
    rd(8'h0C, v); chk("R12 unmapped 0x0C", 64'(v), 64'd0);
    rd(8'h60, v); chk("R12 absent group", 64'(v), 64'd0);
    wr(ra(1, 0), 32'hFFFF_FFFF);
    rd(ra(1, 0), v); chk("R12 lanes above last pin", 64'(v), 64'h0000_FFFF);
    wr(8'h11, 32'hFFFF_FFFF);
    rd(ra(0, 0), v); chk("R12 unaligned write ignored", 64'(v), 64'd0);
    rd(8'h11, v); chk("R12 unaligned read", 64'(v), 64'd0);

    // R2 direction
    wr(ra(0, 0), 32'hA5A5_0F0F);
    rd(ra(0, 0), v); chk("R2 dir readback", 64'(v), 64'hA5A5_0F0F);
    chk("R2 pin_oe", 64'(oe_m), 64'h0000_5A5A_F0F0);
    wr(ra(0, 0), 32'd0); wr(ra(1, 0), 32'd0);
    chk("R2 all outputs", 64'(oe_m), 64'hFFFF_FFFF_FFFF);

    // R3 / R4 single-pin sweep
    for (int p = 0; p < NP; p++) begin
      wr(ra(p / 32, 2), 32'(1) << (p % 32));
      exp_out[p] = 1'b1;
      chk("R3 set sweep", 64'(out_m), 64'(exp_out));
    end
    for (int p = 0; p < NP; p += 2) begin
      wr(ra(p / 32, 3), 32'(1) << (p % 32));
      exp_out[p] = 1'b0;
      chk("R4 clear sweep", 64'(out_m), 64'(exp_out));
    end
    for (int w = 1; w < 4; w++) begin
      rd(ra(0, w), v); chk("R3 out readback words", 64'(v), 64'(exp_out[31:0]));
    end
    wr(ra(0, 3), 32'hFFFF_FFFF); wr(ra(1, 3), 32'hFFFF_FFFF);
    exp_out = '0;
    wr(ra(0, 2), 32'hF0F0_00FF); exp_out[31:0] = 32'hF0F0_00FF;
    wr(ra(0, 3), 32'h0000_000F); exp_out[31:0] = 32'hF0F0_00F0;
    chk("R4 mask clear keeps zeros", 64'(out_m), 64'(exp_out));

    // R5 ignored writes
    wr(ra(0, 1), 32'hFFFF_FFFF);
    wr(ra(1, 1), 32'h0000_0000);
    chk("R5 output-data write ignored", 64'(out_m), 64'(exp_out));
    wr(ra(0, 4), 32'hFFFF_FFFF);
    rd(ra(0, 4), v); chk("R5 input write ignored", 64'(v), 64'd0);

    // R6 input synchroniser latency
    pin_in = 48'hA5C3_1234_5678;
    rd(ra(0, 4), v); chk("R6 read at N old", 64'(v), 64'd0);
    rd(ra(0, 4), v); chk("R6 read at N+1 old", 64'(v), 64'd0);
    rd(ra(0, 4), v); chk("R6 read at N+2 new", 64'(v), 64'h1234_5678);
    rd(ra(1, 4), v); chk("R6 group 1 input", 64'(v), 64'h0000_A5C3);
    pin_in = '0;
    tick(4);

    // R7 enable set/clear
    wr(ra(0, 5), 32'h0000_00FF); wr(ra(0, 6), 32'h0000_000F);
    rd(ra(0, 5), v); chk("R7 rise via set word", 64'(v), 64'h0000_00F0);
    rd(ra(0, 6), v); chk("R7 rise via clear word", 64'(v), 64'h0000_00F0);
    wr(ra(1, 7), 32'h0000_3C00); wr(ra(1, 8), 32'h0000_0400);
    rd(ra(1, 7), v); chk("R7 fall via set word", 64'(v), 64'h0000_3800);
    rd(ra(1, 8), v); chk("R7 fall via clear word", 64'(v), 64'h0000_3800);
    wr(ra(0, 6), 32'hFFFF_FFFF); wr(ra(1, 8), 32'hFFFF_FFFF);

    // R8 / R10 / R11 rising sweep
    wr(8'h08, 32'h7);
    for (int p = 0; p < NP; p++) begin
      int s; logic [31:0] m;
      s = p / 32; m = 32'(1) << (p % 32);
      wr(ra(s, 5), m);
      pin_in[p] = 1'b1;
      tick(3);
      chk("R10 bank line", 64'(bank_m), 64'(3'(1) << (p / 16)));
      if (p < 4) begin
        chk("R11 direct line", 64'(dirq_d), 64'(32'(1) << p));
        chk("R11 bank excluded", 64'(bank_d), 64'd0);
      end else begin
        chk("R11 no direct line", 64'(dirq_d), 64'd0);
        chk("R11 bank used", 64'(bank_d), 64'(3'(1) << (p / 16)));
      end
      rd(ra(s, 9), v); chk("R8 rising latched", 64'(v), 64'(m));
      rd(ra(1 - s, 9), v); chk("R8 other group quiet", 64'(v), 64'd0);
      wr(ra(s, 9), m);
      rd(ra(s, 9), v); chk("R9 w1c clears", 64'(v), 64'd0);
      chk("R10 bank low after clear", 64'(bank_m), 64'd0);
      pin_in[p] = 1'b0;
      tick(3);
      rd(ra(s, 9), v); chk("R8 falling ignored", 64'(v), 64'd0);
      wr(ra(s, 6), m);
    end

    // R8 falling sweep
    pin_in = '1;
    tick(4);
    for (int p = 0; p < NP; p++) begin
      int s; logic [31:0] m;
      s = p / 32; m = 32'(1) << (p % 32);
      wr(ra(s, 7), m);
      pin_in[p] = 1'b0;
      tick(3);
      rd(ra(s, 9), v); chk("R8 falling latched", 64'(v), 64'(m));
      chk("R10 bank on fall", 64'(bank_m), 64'(3'(1) << (p / 16)));
      wr(ra(s, 9), m);
      pin_in[p] = 1'b1;
      tick(3);
      rd(ra(s, 9), v); chk("R8 rising ignored", 64'(v), 64'd0);
      wr(ra(s, 8), m);
    end
    pin_in = '0;
    tick(4);

    // R9 zero bits in clear mask
    wr(ra(0, 5), 32'h0000_0088);
    pin_in[3] = 1'b1; pin_in[7] = 1'b1;
    tick(3);
    wr(ra(0, 9), 32'h0000_0008);
    rd(ra(0, 9), v); chk("R9 partial clear", 64'(v), 64'h0000_0080);
    wr(ra(0, 9), 32'hFFFF_FFFF);
    wr(ra(0, 6), 32'hFFFF_FFFF);
    pin_in = '0;
    tick(4);

    // R10 gating by bank enable
    wr(8'h08, 32'h2);
    wr(ra(0, 5), 32'h0010_0001);
    pin_in[0] = 1'b1;
    tick(3);
    chk("R10 gated bank 0", 64'(bank_m), 64'd0);
    chk("R11 direct ignores gating", 64'(dirq_d), 64'd1);
    pin_in[20] = 1'b1;
    tick(3);
    chk("R10 bank 1 enabled", 64'(bank_m), 64'h2);
    wr(8'h08, 32'h3);
    chk("R10 bank 0 enabled late", 64'(bank_m), 64'h3);
    chk("R11 direct pin not on bank", 64'(bank_d), 64'h2);
    rd(8'h08, v); chk("R10 enable readback", 64'(v), 64'h3);
    wr(ra(0, 9), 32'hFFFF_FFFF);
    wr(ra(0, 6), 32'hFFFF_FFFF);
    pin_in = '0;
    tick(4);

    // R9 edge and clear in the same cycle
    wr(ra(0, 5), 32'h1); wr(ra(0, 7), 32'h1);
    pin_in[0] = 1'b1;
    tick(3);
    rd(ra(0, 9), v); chk("R9 race setup", 64'(v), 64'h1);
    pin_in[0] = 1'b0;
    tick(2);
    wr(ra(0, 9), 32'h1);
    rd(ra(0, 9), v); chk("R9 edge wins over clear", 64'(v), 64'h1);
    pin_in[0] = 1'b1;
    tick(3);
    wr(ra(0, 9), 32'h1);
    rd(ra(0, 9), v); chk("R9 later clear removes", 64'(v), 64'h0);

    summary_and_end();
  end
endmodule